// File: doc/BRIEF.md
# Three-Phase Serial Capture Phase Selector

This block picks which of three host clock phases, spaced 120 degrees apart and running at the serial bit rate, should sample a converter's serial data line. All three phases are modelled as sampling strobes in a single clock domain. Every frame begins with a three-bit preamble of 0, then 1, then 0. After a frame start, each phase records the first three bits it sees on the data line. When the host signals that the header is over, the block compares the three records and selects a phase whose record shows the preamble in the right order.

The selected phase index is reported as a 2-bit code. Value 3 means no phase qualified. A lock flag goes high once the same phase wins on two evaluations in a row. While a phase is selected, every bit that phase samples is passed on to the word receiver as a registered data bit and valid strobe. Each converter gets its own instance, so converters that share one clock but have different propagation delays can each settle on a different phase.

Top module: `phase_pick`

## Requirements
- R1: While reset is held and after it is released, sel is 3, lock is 0 and fwd_vld is 0.
- R2: After a frm_go pulse, each phase i records only the data bits sampled on its first three strobes (ph_stb[i] high). Later strobes before the next frm_go do not change that phase's record.
- R3: A phase qualifies only if it took exactly three samples and they were 0, 1, 0 in time order. A phase with fewer than three samples never qualifies.
- R4: On hdr_done, sel takes the index of the winning phase one cycle later. If exactly one phase qualifies, that phase wins. sel does not change except after hdr_done.
- R5: If all three phases qualify, phase 1 wins.
- R6: If exactly two phases qualify, the later one in circular order wins: pair 0 and 1 gives 1, pair 1 and 2 gives 2, pair 2 and 0 gives 0.
- R7: If no phase qualifies on hdr_done, sel becomes 3 and lock becomes 0.
- R8: On hdr_done, lock becomes 1 only if the new winner equals the sel value held before that hdr_done and is not 3. Otherwise lock becomes 0. lock is never 1 while sel is 3.
- R9: One cycle after a cycle in which ph_stb[sel] is high and sel is not 3, fwd_vld is 1 and fwd_dat equals the data bit from that cycle. Strobes of the other phases, and any strobe while sel is 3, leave fwd_vld at 0.
- R10: frm_go clears every phase's record and sample count. hdr_done with no strobes after frm_go gives sel 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frm_go | input | 1 | Frame start pulse; clears the captures |
| ph_stb | input | 3 | Sampling strobe for each phase; bit i is phase i |
| sdat | input | 1 | Serial data line |
| hdr_done | input | 1 | Header complete; evaluate the captures |
| sel | output | 2 | Chosen phase 0..2, or 3 for none |
| lock | output | 1 | Same phase chosen on two evaluations in a row |
| fwd_vld | output | 1 | Forwarded bit is valid |
| fwd_dat | output | 1 | Forwarded data bit from the chosen phase |

## Verification
A wrong phase record or sample count shows up at the ports on the next hdr_done: sel takes a different value one cycle after that pulse, because the preamble test depends on both the bits and the count. A corrupted lock history shows up as a wrong lock value at that same edge. A wrong selection shows up within one strobe of the chosen phase, as a missing or misplaced fwd_vld. The bench steps through all qualifying patterns, including the ordering rules for two and three passing phases. It also covers short captures, extra strobes and empty frames.

// File: rtl/phase_pick.sv
module phase_pick #(
  parameter int HDR_LEN = 3,
  parameter logic [HDR_LEN-1:0] HDR_PAT = 3'b010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frm_go,
  input  logic [2:0] ph_stb,
  input  logic       sdat,
  input  logic       hdr_done,
  output logic [1:0] sel,
  output logic       lock,
  output logic       fwd_vld,
  output logic       fwd_dat
);
  localparam int NPH = 3;
  localparam int CW = $clog2(HDR_LEN + 1);
  localparam logic [1:0] NONE = 2'd3;

  logic [NPH-1:0] pass;
  logic [1:0]     pick;

  for (genvar i = 0; i < NPH; i++) begin : g_ph
    logic [HDR_LEN-1:0] rec;
    logic [CW-1:0]      cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rec <= '0;
        cnt <= '0;
      end else if (frm_go) begin
        rec <= '0;
        cnt <= '0;
      end else if (ph_stb[i] && cnt != CW'(HDR_LEN)) begin
        rec <= {rec[HDR_LEN-2:0], sdat};
        cnt <= cnt + 1'b1;
      end
    end
    assign pass[i] = (cnt == CW'(HDR_LEN)) && (rec == HDR_PAT);
  end

  always_comb begin
    case (pass)
      3'b001:  pick = 2'd0;
      3'b010:  pick = 2'd1;
      3'b100:  pick = 2'd2;
      3'b011:  pick = 2'd1;
      3'b110:  pick = 2'd2;
      3'b101:  pick = 2'd0;
      3'b111:  pick = 2'd1;
      default: pick = NONE;
    endcase
  end

  wire [3:0] stb4 = {1'b0, ph_stb};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel     <= NONE;
      lock    <= 1'b0;
      fwd_vld <= 1'b0;
      fwd_dat <= 1'b0;
    end else begin
      if (hdr_done) begin
        sel  <= pick;
        lock <= (pick != NONE) && (pick == sel);
      end
      fwd_vld <= stb4[sel];
      fwd_dat <= sdat;
    end
  end
endmodule

// File: rtl/phase_pick_chk.sv
module phase_pick_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hdr_done,
  input logic       sdat,
  input logic [1:0] sel,
  input logic       lock,
  input logic       fwd_vld,
  input logic       fwd_dat
);
  AST_LOCK_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n) lock |-> sel != 2'd3); // R8
  AST_LOCK_ON_EVAL: assert property (@(posedge clk) disable iff (!rst_n) $rose(lock) |-> $past(hdr_done)); // R8
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n) !hdr_done |=> $stable(sel)); // R4
  AST_FWD_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n) fwd_vld |-> $past(sel) != 2'd3); // R9
  AST_FWD_DATA: assert property (@(posedge clk) disable iff (!rst_n) fwd_vld |-> fwd_dat == $past(sdat)); // R9
endmodule

bind phase_pick phase_pick_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hdr_done(hdr_done), .sdat(sdat),
  .sel(sel), .lock(lock), .fwd_vld(fwd_vld), .fwd_dat(fwd_dat)
);

// File: tb/tb_phase_pick.sv
module tb_phase_pick;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_go = 1'b0;
  logic [2:0] ph_stb = 3'b000;
  logic sdat = 1'b0;
  logic hdr_done = 1'b0;
  logic [1:0] sel;
  logic lock, fwd_vld, fwd_dat;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  phase_pick dut (
    .clk(clk), .rst_n(rst_n), .frm_go(frm_go), .ph_stb(ph_stb), .sdat(sdat),
    .hdr_done(hdr_done), .sel(sel), .lock(lock), .fwd_vld(fwd_vld), .fwd_dat(fwd_dat)
  );

  // {p0 bits, p1 bits, p2 bits (first sample in MSB), expected sel, expected lock}
  localparam logic [11:0] VEC [12] = '{
    {3'b010, 3'b010, 3'b010, 2'd1, 1'b0},
    {3'b010, 3'b010, 3'b010, 2'd1, 1'b1},
    {3'b001, 3'b010, 3'b100, 2'd1, 1'b1},
    {3'b010, 3'b010, 3'b001, 2'd1, 1'b1},
    {3'b000, 3'b010, 3'b010, 2'd2, 1'b0},
    {3'b010, 3'b000, 3'b010, 2'd0, 1'b0},
    {3'b010, 3'b011, 3'b110, 2'd0, 1'b1},
    {3'b000, 3'b000, 3'b000, 2'd3, 1'b0},
    {3'b110, 3'b010, 3'b101, 2'd1, 1'b0},
    {3'b001, 3'b001, 3'b010, 2'd2, 1'b0},
    {3'b001, 3'b001, 3'b010, 2'd2, 1'b1},
    {3'b101, 3'b011, 3'b111, 2'd3, 1'b0}
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(int ph, logic b);
    ph_stb = 3'b001 << ph;
    sdat = b;
    @(negedge clk);
    ph_stb = 3'b000;
  endtask

  task automatic start();
    frm_go = 1'b1;
    @(negedge clk);
    frm_go = 1'b0;
  endtask

  task automatic eval();
    hdr_done = 1'b1;
    @(negedge clk);
    hdr_done = 1'b0;
  endtask

  task automatic frame(logic [2:0] p0, logic [2:0] p1, logic [2:0] p2);
    start();
    for (int k = 2; k >= 0; k--) begin
      strobe(0, p0[k]);
      strobe(1, p1[k]);
      strobe(2, p2[k]);
    end
    eval();
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 sel in reset", sel, 3);
    check("R1 lock in reset", lock, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sel after reset", sel, 3);
    check("R1 fwd_vld after reset", fwd_vld, 0);
    strobe(0, 1'b1);
    check("R9 no forward while none selected", fwd_vld, 0);

    // R4 R5 R6 R7 R8: table walk
    for (int v = 0; v < 12; v++) begin
      frame(VEC[v][11:9], VEC[v][8:6], VEC[v][5:3]);
      check($sformatf("R4-R8 vec%0d sel", v), sel, int'(VEC[v][2:1]));
      check($sformatf("R8 vec%0d lock", v), lock, int'(VEC[v][0]));
    end

    // R3: phase 0 gets only two samples, 1 then 0 (record bits look like 010)
    start();
    strobe(0, 1'b1);
    strobe(0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      strobe(1, 1'b0);
      strobe(2, 1'b1);
    end
    eval();
    check("R3 short capture rejected", sel, 3);

    // R2: extra strobes after three samples ignored
    start();
    strobe(1, 1'b0); strobe(1, 1'b1); strobe(1, 1'b0);
    strobe(1, 1'b1); strobe(1, 1'b1);
    for (int k = 0; k < 3; k++) begin
      strobe(0, 1'b1);
      strobe(2, 1'b0);
    end
    eval();
    check("R2 extra samples ignored", sel, 1);

    // R10: frm_go clears records
    frame(3'b000, 3'b010, 3'b000);
    check("R10 setup sel", sel, 1);
    check("R8 repeat lock", lock, 1);
    strobe(1, 1'b1);
    check("R9 chosen phase forwards vld", fwd_vld, 1);
    check("R9 chosen phase forwards data", fwd_dat, 1);
    strobe(1, 1'b0);
    check("R9 forwards zero", fwd_dat, 0);
    check("R9 forwards zero vld", fwd_vld, 1);
    strobe(0, 1'b1);
    check("R9 other phase blocked", fwd_vld, 0);
    strobe(2, 1'b1);
    check("R9 other phase 2 blocked", fwd_vld, 0);
    check("R4 sel held without eval", sel, 1);
    start();
    eval();
    check("R10 empty frame sel", sel, 3);
    check("R7 lock dropped", lock, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule